// File: doc/BRIEF.md
# Hash Table Build Engine

This block fills a hash table that lives in external memory. It takes build tuples from a stream, one per cycle, and links each one into the bucket chosen by its key. A bucket is a single head pointer. Collisions are handled by separate chaining: each bucket heads a singly linked list of nodes in memory, and a pointer of zero means an empty bucket or the end of a list.

Each accepted tuple becomes an independent thread. The engine hashes the key to a bucket index and takes the next node address from a bump allocator. It then issues an atomic exchange that puts the new node address into the bucket and returns the bucket's previous head. When that response arrives, the engine writes the node: key, payload, and the previous head as the next pointer. Outstanding exchanges are tracked by tag, so responses may come back in any order. Because the head update is a single atomic swap, many inserts into the same bucket can be in flight at once without losing nodes.

The engine raises a sticky done flag once the tuple marked last has been accepted and every node write has been acknowledged.

Top module: `hash_build_engine`

## Requirements
- R1: After reset, xchgValid, nodeWrValid and done are 0, and tupleReady is 1.
- R2: When free tags exist and the exchange port is ready, a tuple is accepted on every clock cycle, with no bubbles.
- R3: A tuple is 64 bits wide, with the key in bits [31:0] and the payload in bits [63:32]. The node write for a tuple carries exactly that key and that payload.
- R4: The bucket index sent with the exchange is the top BKT_W bits of the low 32 bits of key * 32'h9E3779B1.
- R5: Node addresses are nodeBase + 16*n, where n counts accepted tuples from 0 in acceptance order. Exchanges are issued in acceptance order.
- R6: The exchange writes the new node address (xchgData) into the bucket. The previous head returned for that exchange's tag is written as the node's next pointer, at the same node address.
- R7: Exchange responses may return out of order. Each response is matched to its request by tag, and a tag is not reissued while its exchange is unanswered.
- R8: With TAGS inserts waiting on exchange responses, tupleReady is 0 and no further tuple is accepted.
- R9: done stays 0 until the node writes of all tuples, up to and including the one flagged tupleLast, have been acknowledged. It then rises within a few cycles and stays high.
- R10: After all inserts, walking every bucket list from its head through the next pointers, up to a zero pointer, visits each inserted node exactly once, even when many tuples share a bucket.
- R11: While xchgValid or nodeWrValid is high and its ready input is low, that request and its fields hold stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nodeBase | input | ADDR_W | Start address of the node region (nonzero) |
| tupleValid | input | 1 | Tuple on tupleData is valid |
| tupleData | input | 64 | {payload, key} |
| tupleLast | input | 1 | Marks the final build tuple |
| tupleReady | output | 1 | Engine accepts the tuple this cycle |
| xchgValid | output | 1 | Atomic exchange request valid |
| xchgReady | input | 1 | Memory takes the exchange request |
| xchgTag | output | TAG_W | Tag of the exchange request |
| xchgBucket | output | BKT_W | Bucket index to swap |
| xchgData | output | ADDR_W | New head value (the new node address) |
| respValid | input | 1 | Exchange response valid |
| respTag | input | TAG_W | Tag of the response |
| respOld | input | ADDR_W | Previous bucket head |
| nodeWrValid | output | 1 | Node write valid |
| nodeWrReady | input | 1 | Memory takes the node write |
| nodeWrAddr | output | ADDR_W | Node address |
| nodeWrKey | output | 32 | Node key |
| nodeWrPayload | output | 32 | Node payload |
| nodeWrNext | output | ADDR_W | Node next pointer |
| ackValid | input | 1 | One node write acknowledged |
| done | output | 1 | All inserts are complete |

## Verification
The hardest case to reach is many unanswered exchanges on one bucket whose responses return out of order while the node-write port is throttled. Only this case shows whether every previous head is paired with the right node. To reach it, the stimulus first withholds all responses until the tag table fills, which also exposes the stall. It then releases responses in random tag order with random backpressure on both request ports, and it feeds a run of tuples that share one key. The final list walk over the modelled memory then exposes any lost or mislinked node.

// File: rtl/hbe_pkg.sv
package hbe_pkg;
  localparam logic [31:0] HASH_MULT = 32'h9E3779B1;

  typedef struct packed {
    logic accept;   // tuple taken, new thread allocated
    logic capture;  // exchange response stored
    logic loadWr;   // node write output register loaded
  } hbeStrobe_t;

  function automatic logic [31:0] mixKey(input logic [31:0] key);
    return key * HASH_MULT;
  endfunction
endpackage

// File: rtl/hbe_datapath.sv
module hbe_datapath
  import hbe_pkg::*;
#(
  parameter int TAGS   = 8,
  parameter int ADDR_W = 32,
  parameter int BKT_W  = 6,
  parameter int NODE_BYTES = 16,
  localparam int TAG_W = $clog2(TAGS),
  localparam int SHIFT = $clog2(NODE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hbeStrobe_t        strobe,
  input  logic [TAG_W-1:0]  allocTag,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [ADDR_W-1:0] nodeBase,
  input  logic [63:0]       tupleData,
  input  logic [TAG_W-1:0]  respTag,
  input  logic [ADDR_W-1:0] respOld,
  output logic [TAG_W-1:0]  xchgTag,
  output logic [BKT_W-1:0]  xchgBucket,
  output logic [ADDR_W-1:0] xchgData,
  output logic [ADDR_W-1:0] nodeWrAddr,
  output logic [31:0]       nodeWrKey,
  output logic [31:0]       nodeWrPayload,
  output logic [ADDR_W-1:0] nodeWrNext
);
  logic [31:0]       keyMem  [TAGS];
  logic [31:0]       payMem  [TAGS];
  logic [ADDR_W-1:0] addrMem [TAGS];
  logic [ADDR_W-1:0] nextMem [TAGS];
  logic [ADDR_W-1:0] bumpCount;
  logic [ADDR_W-1:0] newAddr;
  logic [31:0]       mixed;

  assign newAddr = nodeBase + (bumpCount << SHIFT);
  assign mixed   = mixKey(tupleData[31:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) bumpCount <= '0;
    else if (strobe.accept) bumpCount <= bumpCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.accept) begin
      keyMem[allocTag]  <= tupleData[31:0];
      payMem[allocTag]  <= tupleData[63:32];
      addrMem[allocTag] <= newAddr;
    end
    if (strobe.capture) nextMem[respTag] <= respOld;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xchgTag    <= '0;
      xchgBucket <= '0;
      xchgData   <= '0;
    end else if (strobe.accept) begin
      xchgTag    <= allocTag;
      xchgBucket <= mixed[31 -: BKT_W];
      xchgData   <= newAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nodeWrAddr    <= '0;
      nodeWrKey     <= '0;
      nodeWrPayload <= '0;
      nodeWrNext    <= '0;
    end else if (strobe.loadWr) begin
      nodeWrAddr    <= addrMem[wrTag];
      nodeWrKey     <= keyMem[wrTag];
      nodeWrPayload <= payMem[wrTag];
      nodeWrNext    <= nextMem[wrTag];
    end
  end
endmodule

// File: rtl/hbe_ctrl.sv
module hbe_ctrl
  import hbe_pkg::*;
#(
  parameter int TAGS  = 8,
  parameter int ACK_W = 16,
  localparam int TAG_W = $clog2(TAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tupleValid,
  input  logic             tupleLast,
  output logic             tupleReady,
  output logic             xchgValid,
  input  logic             xchgReady,
  input  logic             respValid,
  input  logic [TAG_W-1:0] respTag,
  output logic             nodeWrValid,
  input  logic             nodeWrReady,
  input  logic             ackValid,
  output logic             done,
  output hbeStrobe_t       strobe,
  output logic [TAG_W-1:0] allocTag,
  output logic [TAG_W-1:0] wrTag,
  output logic [TAGS-1:0]  busyVec
);
  logic [TAGS-1:0]  answered;
  logic             anyFree, anyAnswered, lastSeen;
  logic [ACK_W-1:0] pendAck;

  always_comb begin
    anyFree  = 1'b0;
    allocTag = '0;
    for (int i = TAGS - 1; i >= 0; i--) begin
      if (!busyVec[i]) begin
        anyFree  = 1'b1;
        allocTag = TAG_W'(i);
      end
    end
  end

  always_comb begin
    anyAnswered = 1'b0;
    wrTag       = '0;
    for (int i = TAGS - 1; i >= 0; i--) begin
      if (answered[i]) begin
        anyAnswered = 1'b1;
        wrTag       = TAG_W'(i);
      end
    end
  end

  assign tupleReady     = anyFree && (!xchgValid || xchgReady) && !lastSeen;
  assign strobe.accept  = tupleValid && tupleReady;
  assign strobe.capture = respValid;
  assign strobe.loadWr  = anyAnswered && (!nodeWrValid || nodeWrReady);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyVec  <= '0;
      answered <= '0;
    end else begin
      if (strobe.accept)  busyVec[allocTag] <= 1'b1;
      if (strobe.capture) answered[respTag] <= 1'b1;
      if (strobe.loadWr) begin
        busyVec[wrTag]  <= 1'b0;
        answered[wrTag] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xchgValid   <= 1'b0;
      nodeWrValid <= 1'b0;
      lastSeen    <= 1'b0;
      pendAck     <= '0;
      done        <= 1'b0;
    end else begin
      if (strobe.accept)  xchgValid <= 1'b1;
      else if (xchgReady) xchgValid <= 1'b0;
      if (strobe.loadWr)    nodeWrValid <= 1'b1;
      else if (nodeWrReady) nodeWrValid <= 1'b0;
      if (strobe.accept && tupleLast) lastSeen <= 1'b1;
      pendAck <= pendAck + ACK_W'(nodeWrValid && nodeWrReady) - ACK_W'(ackValid);
      if (lastSeen && busyVec == '0 && !xchgValid && !nodeWrValid && pendAck == '0)
        done <= 1'b1;
    end
  end
endmodule

// File: rtl/hash_build_engine.sv
module hash_build_engine
  import hbe_pkg::*;
#(
  parameter int TAGS   = 8,
  parameter int ADDR_W = 32,
  parameter int BKT_W  = 6,
  parameter int ACK_W  = 16,
  localparam int TAG_W = $clog2(TAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] nodeBase,
  input  logic              tupleValid,
  input  logic [63:0]       tupleData,
  input  logic              tupleLast,
  output logic              tupleReady,
  output logic              xchgValid,
  input  logic              xchgReady,
  output logic [TAG_W-1:0]  xchgTag,
  output logic [BKT_W-1:0]  xchgBucket,
  output logic [ADDR_W-1:0] xchgData,
  input  logic              respValid,
  input  logic [TAG_W-1:0]  respTag,
  input  logic [ADDR_W-1:0] respOld,
  output logic              nodeWrValid,
  input  logic              nodeWrReady,
  output logic [ADDR_W-1:0] nodeWrAddr,
  output logic [31:0]       nodeWrKey,
  output logic [31:0]       nodeWrPayload,
  output logic [ADDR_W-1:0] nodeWrNext,
  input  logic              ackValid,
  output logic              done
);
  hbeStrobe_t       strobe;
  logic [TAG_W-1:0] allocTag, wrTag;
  logic [TAGS-1:0]  busyVec;

  hbe_ctrl #(.TAGS(TAGS), .ACK_W(ACK_W)) ctrl (
    .clk(clk), .rst_n(rst_n), .tupleValid(tupleValid), .tupleLast(tupleLast),
    .tupleReady(tupleReady), .xchgValid(xchgValid), .xchgReady(xchgReady),
    .respValid(respValid), .respTag(respTag), .nodeWrValid(nodeWrValid),
    .nodeWrReady(nodeWrReady), .ackValid(ackValid), .done(done),
    .strobe(strobe), .allocTag(allocTag), .wrTag(wrTag), .busyVec(busyVec)
  );

  hbe_datapath #(.TAGS(TAGS), .ADDR_W(ADDR_W), .BKT_W(BKT_W)) dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .allocTag(allocTag), .wrTag(wrTag),
    .nodeBase(nodeBase), .tupleData(tupleData), .respTag(respTag), .respOld(respOld),
    .xchgTag(xchgTag), .xchgBucket(xchgBucket), .xchgData(xchgData),
    .nodeWrAddr(nodeWrAddr), .nodeWrKey(nodeWrKey), .nodeWrPayload(nodeWrPayload),
    .nodeWrNext(nodeWrNext)
  );
endmodule

// File: rtl/hbe_checker.sv
module hbe_checker #(
  parameter int TAGS   = 8,
  parameter int ADDR_W = 32,
  parameter int BKT_W  = 6,
  localparam int TAG_W = $clog2(TAGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] nodeBase,
  input logic              tupleValid,
  input logic              tupleReady,
  input logic              xchgValid,
  input logic              xchgReady,
  input logic [TAG_W-1:0]  xchgTag,
  input logic [BKT_W-1:0]  xchgBucket,
  input logic [ADDR_W-1:0] xchgData,
  input logic              respValid,
  input logic              nodeWrValid,
  input logic              nodeWrReady,
  input logic [ADDR_W-1:0] nodeWrAddr,
  input logic [31:0]       nodeWrKey,
  input logic [31:0]       nodeWrPayload,
  input logic [ADDR_W-1:0] nodeWrNext,
  input logic              done
);
  int unsigned unanswered;

  always_ff @(posedge clk) begin
    if (!rst_n) unanswered <= 0;
    else unanswered <= unanswered + 32'(tupleValid && tupleReady) - 32'(respValid);
  end

  assert_stall_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (unanswered == TAGS) |-> !tupleReady);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unanswered <= TAGS);

  assert_xchg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (xchgValid && !xchgReady) |=> (xchgValid && $stable(xchgTag) && $stable(xchgBucket)
                                   && $stable(xchgData)));

  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (nodeWrValid && !nodeWrReady) |=> (nodeWrValid && $stable(nodeWrAddr) && $stable(nodeWrKey)
                                       && $stable(nodeWrPayload) && $stable(nodeWrNext)));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!xchgValid && !nodeWrValid && !tupleReady));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_addr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xchgValid && nodeBase != '0) |-> (xchgData != '0));
endmodule

bind hash_build_engine hbe_checker #(.TAGS(TAGS), .ADDR_W(ADDR_W), .BKT_W(BKT_W)) chk (
  .clk(clk), .rst_n(rst_n), .nodeBase(nodeBase), .tupleValid(tupleValid),
  .tupleReady(tupleReady), .xchgValid(xchgValid), .xchgReady(xchgReady),
  .xchgTag(xchgTag), .xchgBucket(xchgBucket), .xchgData(xchgData),
  .respValid(respValid), .nodeWrValid(nodeWrValid), .nodeWrReady(nodeWrReady),
  .nodeWrAddr(nodeWrAddr), .nodeWrKey(nodeWrKey), .nodeWrPayload(nodeWrPayload),
  .nodeWrNext(nodeWrNext), .done(done)
);

// File: tb/hash_build_engine_test.sv
module hash_build_engine_test;
  localparam int TAGS = 8, ADDR_W = 32, BKT_W = 6, TAG_W = 3, N = 40;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 0, rst_n = 0;
  logic tupleValid = 0, tupleLast = 0, xchgReady = 0, respValid = 0, nodeWrReady = 0, ackValid = 0;
  logic [63:0] tupleData = 0;
  logic [TAG_W-1:0] respTag = 0;
  logic [ADDR_W-1:0] respOld = 0;
  logic tupleReady, xchgValid, nodeWrValid, done;
  logic [TAG_W-1:0] xchgTag;
  logic [BKT_W-1:0] xchgBucket;
  logic [ADDR_W-1:0] xchgData, nodeWrAddr, nodeWrNext;
  logic [31:0] nodeWrKey, nodeWrPayload;

  always #2 clk = ~clk;

  hash_build_engine uut (
    .clk(clk), .rst_n(rst_n), .nodeBase(BASE), .tupleValid(tupleValid), .tupleData(tupleData),
    .tupleLast(tupleLast), .tupleReady(tupleReady), .xchgValid(xchgValid), .xchgReady(xchgReady),
    .xchgTag(xchgTag), .xchgBucket(xchgBucket), .xchgData(xchgData), .respValid(respValid),
    .respTag(respTag), .respOld(respOld), .nodeWrValid(nodeWrValid), .nodeWrReady(nodeWrReady),
    .nodeWrAddr(nodeWrAddr), .nodeWrKey(nodeWrKey), .nodeWrPayload(nodeWrPayload),
    .nodeWrNext(nodeWrNext), .ackValid(ackValid), .done(done)
  );

  int errors = 0, checks = 0;
  logic [31:0] keys [N];
  logic [31:0] pays [N];
  logic [31:0] head [1 << BKT_W];
  logic [31:0] oldOf [logic [31:0]];
  int          idxOf [logic [31:0]];
  logic [31:0] memNext [logic [31:0]];
  logic [31:0] memKey [logic [31:0]];
  int xq[$];
  int ackQ[$];
  bit pendV [TAGS];
  logic [31:0] pendOld [TAGS];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BKT_W-1:0] bucketOf(input logic [31:0] k);
    logic [31:0] p;
    p = k * 32'h9E3779B1;
    return p[31:32-BKT_W];
  endfunction

  initial begin
    int cyc = 0, sent = 0, xcount = 0, writes = 0, acks = 0, early = 0;
    bit earlyDone = 0;
    for (int i = 0; i < N; i++) begin
      keys[i] = (i >= 12 && i < 22) ? 32'd777 : 32'(i * 7919 + 3);
      pays[i] = 32'hA000_0000 + 32'(i);
    end
    for (int b = 0; b < (1 << BKT_W); b++) head[b] = 0;
    for (int t = 0; t < TAGS; t++) pendV[t] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check(!xchgValid && !nodeWrValid && !done, "R1", {xchgValid, nodeWrValid, done}, 0);
    check(tupleReady, "R1", tupleReady, 1);
    while (cyc < 20000) begin
      @(negedge clk);
      cyc++;
      tupleValid = (sent < N) && ((cyc <= 20) ? 1'b1 : ($urandom % 4 != 0));
      tupleData  = (sent < N) ? {pays[sent], keys[sent]} : 64'h0;
      tupleLast  = (sent == N - 1);
      xchgReady  = (cyc <= 20) ? 1'b1 : ($urandom % 4 != 0);
      nodeWrReady = ($urandom % 3 != 0);
      respValid = 0;
      if (cyc > 20 && ($urandom % 2 == 1)) begin
        int s;
        s = $urandom % TAGS;
        for (int k = 0; k < TAGS; k++) begin
          int t;
          t = (s + k) % TAGS;
          if (!respValid && pendV[t]) begin
            respValid = 1; respTag = TAG_W'(t); respOld = pendOld[t]; pendV[t] = 0;
          end
        end
      end
      ackValid = 0;
      if (ackQ.size() > 0 && ackQ[0] <= cyc) begin
        void'(ackQ.pop_front()); ackValid = 1; acks++;
      end
      #1;
      if (tupleValid && tupleReady) begin
        xq.push_back(sent);
        sent++;
        if (cyc <= TAGS) early++;
      end
      if (xchgValid && xchgReady) begin
        int i;
        i = xq.pop_front();
        check(xchgBucket == bucketOf(keys[i]), "R4", xchgBucket, bucketOf(keys[i]));
        check(xchgData == BASE + 32'(16 * xcount), "R5", xchgData, BASE + 32'(16 * xcount));
        check(!pendV[xchgTag], "R7", xchgTag, 0);
        oldOf[xchgData] = head[xchgBucket];
        idxOf[xchgData] = i;
        head[xchgBucket] = xchgData;
        pendV[xchgTag] = 1;
        pendOld[xchgTag] = oldOf[xchgData];
        xcount++;
      end
      if (nodeWrValid && nodeWrReady) begin
        if (idxOf.exists(nodeWrAddr)) begin
          int i;
          i = idxOf[nodeWrAddr];
          check(nodeWrKey == keys[i], "R3", nodeWrKey, keys[i]);
          check(nodeWrPayload == pays[i], "R3", nodeWrPayload, pays[i]);
          check(nodeWrNext == oldOf[nodeWrAddr], "R6", nodeWrNext, oldOf[nodeWrAddr]);
        end else check(0, "R6", nodeWrAddr, 0);
        memNext[nodeWrAddr] = nodeWrNext;
        memKey[nodeWrAddr] = nodeWrKey;
        ackQ.push_back(cyc + 2);
        writes++;
      end
      if (done && acks < N) earlyDone = 1;
      if (cyc == TAGS) check(early == TAGS, "R2", early, TAGS);
      if (cyc == 20) begin
        check(sent == TAGS, "R8", sent, TAGS);
        check(!tupleReady, "R8", tupleReady, 0);
      end
      if (acks == N && ackQ.size() == 0) begin
        repeat (4) @(negedge clk);
        break;
      end
    end
    ackValid = 0; tupleValid = 0; respValid = 0;
    check(cyc < 20000, "R9", cyc, 20000);
    check(!earlyDone, "R9", earlyDone, 0);
    check(done, "R9", done, 1);
    check(writes == N, "R6", writes, N);
    begin
      int visited = 0;
      bit seen [int];
      bit dup = 0;
      for (int b = 0; b < (1 << BKT_W); b++) begin
        logic [31:0] p;
        int steps = 0;
        p = head[b];
        while (p != 0 && steps < 200 && memNext.exists(p)) begin
          if (seen.exists(idxOf[p])) dup = 1;
          seen[idxOf[p]] = 1;
          visited++;
          p = memNext[p];
          steps++;
        end
      end
      check(visited == N, "R10", visited, N);
      check(!dup && seen.size() == N, "R10", seen.size(), N);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule